// File: doc/BRIEF.md
# Sensor Acquisition Trigger Controller

This block decides which image-sensor frames reach the capture pipeline. Software programs a small control word through a 32-bit write port. The sensor supplies frame-start and frame-end pulses and a line-valid level. The block returns a gated line-valid, `pix_valid_out`, for the downstream pixel path, and a status flag, `acq_active`, that is high while the channel is enabled.

There are two capture modes and two trigger sources. In continuous mode every frame passes. In single mode one frame passes, the channel then disables itself, and the stored frame is safe from being overwritten. An external trigger input can hold each frame back until a trigger edge has been seen. Clearing the enable bit stops the output at once, even in the middle of a line. A programmed line count can cut a frame short.

Top module: `acq_trigger_ctrl`

## Requirements
- R1: After reset, `acq_active` and `pix_valid_out` are low, and no line passes until the channel is enabled.
- R2: A write stores only bits 2..0 of `wr_data`: bit 2 enables the channel, bit 1 selects the external trigger (1) or the internal trigger (0), and bit 0 selects continuous capture (1) or single capture (0). Bits 31..3 have no effect. `acq_active` shows bit 2 in the cycle after the write.
- R3: In continuous mode every frame opens a pass window. While the window is open, `pix_valid_out` follows `line_valid` in the same cycle.
- R4: A window opens only on a frame-start pulse sampled while the channel is enabled. Lines that remain of a frame already running when the channel is armed are blocked.
- R5: In single mode, once `frame_lines` lines have ended, the window closes and the enable bit clears itself. `acq_active` falls, and later frames are blocked.
- R6: Frame end closes the window even if the line count has not been reached, and in single mode it also clears the enable bit. A `frame_lines` value of 0 means the window stays open until frame end.
- R7: A write with bit 2 clear aborts capture. `pix_valid_out` is low from the cycle after the write, even in the middle of a line, and `acq_active` falls at the same time.
- R8: With the external trigger selected, a frame start is accepted only after a rising edge of the synchronised `ext_trig`. Each accepted edge admits exactly one frame.
- R9: Trigger edges that occur while the channel is disabled are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 32 | Control write data; only bits 2..0 are used |
| frame_lines | input | LINE_W | Lines to pass per frame; 0 means the whole frame |
| sof | input | 1 | Sensor frame-start pulse |
| eof | input | 1 | Sensor frame-end pulse |
| line_valid | input | 1 | Sensor line-valid level |
| ext_trig | input | 1 | Asynchronous external trigger |
| pix_valid_out | output | 1 | Gated line-valid toward the pixel path |
| acq_active | output | 1 | High while the channel is enabled |

## Verification
Each result falls due in a fixed cycle:
- `acq_active` changes one edge after a write.
- A window opens on the edge that samples `sof`.
- An abort gates the output one edge after the write.
- A self-disable lands on the edge that first sees `line_valid` low after the last counted line.
- An `ext_trig` edge becomes usable SYNC_STAGES+1 edges after it occurs.

The bench drives inputs on falling edges and samples outputs on the next falling edge. Each sample therefore reflects exactly one rising edge of state update. The bench counts passed line-valid cycles per frame and compares the total with `lines*line_length` computed from the mode, the line count and the write position. It leaves wide idle gaps around trigger pulses and writes so that no result depends on the synchroniser delay.

// File: rtl/acq_pkg.sv
// Package: shared field positions and types for the acquisition trigger controller.
// Assumes a 32-bit control write port of which only the low bits are decoded.
package acq_pkg;
    localparam int unsigned CTRL_W    = 32;
    localparam int unsigned CTRL_USED = 3;
    localparam int unsigned BIT_CONT  = 0;
    localparam int unsigned BIT_EXT   = 1;
    localparam int unsigned BIT_EN    = 2;

    typedef struct packed {
        logic en;
        logic ext;
        logic cont;
    } acq_ctrl_t;

    typedef enum logic {
        GATE_HUNT = 1'b0,
        GATE_OPEN = 1'b1
    } gate_state_t;
endpackage

// File: rtl/acq_trig_sync.sv
// Synchronises the asynchronous trigger input and emits a one-cycle pulse on
// each rising edge. Assumes STAGES >= 2 for metastability settling.
module acq_trig_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic trig_rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the raw trigger through the synchroniser and keep the previous output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= (sync_q << 1) | STAGES'(trig_in);
            last_q <= sync_q[STAGES-1];
        end
    end

    assign trig_rise = sync_q[STAGES-1] & ~last_q;

    // One edge yields one pulse (R8).
    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rise |=> !trig_rise);
endmodule

// File: rtl/acq_ctrl_reg.sv
// Control register: latches the mode bits from the write port and clears the
// enable bit when the frame gate requests it. A write in the same cycle wins.
module acq_ctrl_reg
    import acq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              self_clr,
    output acq_ctrl_t         ctrl
);
    logic unused_upper;
    assign unused_upper = ^wr_data[CTRL_W-1:CTRL_USED];

    // Load the decoded bits on a write, otherwise honour a self-clear request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl.en   <= wr_data[BIT_EN];
            ctrl.ext  <= wr_data[BIT_EXT];
            ctrl.cont <= wr_data[BIT_CONT];
        end else if (self_clr) begin
            ctrl.en <= 1'b0;
        end
    end

    assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl.en == $past(wr_data[BIT_EN])) && (ctrl.cont == $past(wr_data[BIT_CONT])));

    assert_self_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (self_clr && !wr_en) |=> !ctrl.en);
endmodule

// File: rtl/acq_frame_gate.sv
// Frame gate: opens a pass window on a clean frame start, counts line ends,
// closes on the line count or frame end, and requests the self-disable in
// single mode. Assumes sof and eof are one-cycle pulses and are never high
// together, and that line_valid is low in the sof cycle.
module acq_frame_gate
    import acq_pkg::*;
#(
    parameter int unsigned LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acq_ctrl_t         ctrl,
    input  logic [LINE_W-1:0] frame_lines,
    input  logic              sof,
    input  logic              eof,
    input  logic              line_valid,
    input  logic              trig_rise,
    output logic              pix_valid,
    output logic              done
);
    gate_state_t       state;
    logic              lv_q;
    logic              trig_seen;
    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] line_next;
    logic              line_end;
    logic              lines_hit;
    logic              trig_ok;
    logic              open_now;
    logic              close_now;

    // Decode line ends, the count limit and the open/close conditions.
    always_comb begin
        line_next = line_cnt + LINE_W'(1);
        line_end  = lv_q & ~line_valid;
        lines_hit = (frame_lines != '0) && (line_next == frame_lines);
        trig_ok   = ~ctrl.ext | trig_seen | trig_rise;
        open_now  = (state == GATE_HUNT) & ctrl.en & sof & trig_ok;
        close_now = (state == GATE_OPEN) & ((line_end & lines_hit) | eof);
    end

    // Window state: abort takes priority, then open, then close.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl.en) begin
            state <= GATE_HUNT;
        end else if (open_now) begin
            state <= GATE_OPEN;
        end else if (close_now) begin
            state <= GATE_HUNT;
        end
    end

    // Line counter and line-valid history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt <= '0;
            lv_q     <= 1'b0;
        end else begin
            lv_q <= line_valid;
            if (open_now) begin
                line_cnt <= '0;
            end else if (state == GATE_OPEN && line_end) begin
                line_cnt <= line_next;
            end
        end
    end

    // Trigger latch: keeps an edge seen while armed until a frame consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl.en || !ctrl.ext || open_now) begin
            trig_seen <= 1'b0;
        end else if (trig_rise) begin
            trig_seen <= 1'b1;
        end
    end

    assign pix_valid = line_valid & ctrl.en & (state == GATE_OPEN);
    assign done      = close_now & ctrl.en & ~ctrl.cont;

    assert_open_on_sof_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GATE_HUNT) |=> (state == GATE_HUNT) || $past(sof && ctrl.en));

    assert_eof_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GATE_OPEN && eof) |=> (state == GATE_HUNT));

    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |=> (state == GATE_HUNT));

    assert_ext_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GATE_HUNT && ctrl.ext && !trig_seen && !trig_rise) |=> (state == GATE_HUNT));
endmodule

// File: rtl/acq_trigger_ctrl.sv
// Top: connects the control register, trigger synchroniser and frame gate.
// Assumes sensor timing signals are synchronous to clk.
module acq_trigger_ctrl
    import acq_pkg::*;
#(
    parameter int unsigned LINE_W      = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic [LINE_W-1:0] frame_lines,
    input  logic              sof,
    input  logic              eof,
    input  logic              line_valid,
    input  logic              ext_trig,
    output logic              pix_valid_out,
    output logic              acq_active
);
    acq_ctrl_t ctrl;
    logic      self_clr;
    logic      trig_rise;

    acq_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .self_clr (self_clr),
        .ctrl     (ctrl)
    );

    acq_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (ext_trig),
        .trig_rise (trig_rise)
    );

    acq_frame_gate #(.LINE_W(LINE_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl        (ctrl),
        .frame_lines (frame_lines),
        .sof         (sof),
        .eof         (eof),
        .line_valid  (line_valid),
        .trig_rise   (trig_rise),
        .pix_valid   (pix_valid_out),
        .done        (self_clr)
    );

    assign acq_active = ctrl.en;
endmodule

// File: tb/acq_trigger_ctrl_test.sv
`timescale 1ns/1ps
module acq_trigger_ctrl_test;
    localparam int LW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [LW-1:0] frame_lines = '0;
    logic          sof = 1'b0;
    logic          eof = 1'b0;
    logic          line_valid = 1'b0;
    logic          ext_trig = 1'b0;
    logic          pix_valid_out;
    logic          acq_active;

    int checks = 0;
    int bad = 0;
    int acc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    acq_trigger_ctrl #(.LINE_W(LW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .frame_lines(frame_lines), .sof(sof), .eof(eof), .line_valid(line_valid),
        .ext_trig(ext_trig), .pix_valid_out(pix_valid_out), .acq_active(acq_active)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: sample the output of the cycle just ended, then drive the next.
    task automatic tick(input logic s, input logic e, input logic lv, input logic w, input logic [31:0] wd);
        @(negedge clk);
        acc += int'(pix_valid_out);
        sof = s; eof = e; line_valid = lv; wr_en = w; wr_data = wd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, '0);
    endtask

    task automatic do_write(input logic [31:0] v);
        tick(0, 0, 0, 1, v);
        tick(0, 0, 0, 0, '0);
    endtask

    task automatic pulse_trig();
        ext_trig = 1'b1;
        idle(3);
        ext_trig = 1'b0;
        idle(6);
    endtask

    // Frame of nl lines of ll pixels; optional write in line wl at pixel wp (wp<0: gap before the line).
    task automatic run_frame(input int nl, input int ll, input int wl, input int wp,
                             input logic [31:0] wv, output int got);
        acc = 0;
        tick(1, 0, 0, 0, '0);
        tick(0, 0, 0, 0, '0);
        for (int l = 0; l < nl; l++) begin
            if (l == wl && wp < 0) tick(0, 0, 0, 1, wv);
            for (int p = 0; p < ll; p++)
                tick(0, 0, 1, (l == wl && p == wp), (l == wl && p == wp) ? wv : 32'h0);
            tick(0, 0, 0, 0, '0);
            tick(0, 0, 0, 0, '0);
        end
        tick(0, 1, 0, 0, '0);
        tick(0, 0, 0, 0, '0);
        tick(0, 0, 0, 0, '0);
        got = acc;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int got;
        int eff;
        int exp;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1: reset state and nothing passes before arming
        check(acq_active == 1'b0, "R1 acq_active after reset", int'(acq_active), 0);
        check(pix_valid_out == 1'b0, "R1 pix_valid_out after reset", int'(pix_valid_out), 0);
        run_frame(3, 4, -1, -1, 0, got);
        check(got == 0, "R1 unarmed frame", got, 0);

        // R2: upper bits ignored
        do_write(32'hFFFF_FFF8);
        check(acq_active == 1'b0, "R2 upper bits only", int'(acq_active), 0);
        run_frame(3, 4, -1, -1, 0, got);
        check(got == 0, "R2 upper bits do not enable", got, 0);
        frame_lines = '0;
        do_write(32'hFFFF_FFFC);
        check(acq_active == 1'b1, "R2 enable via bit 2", int'(acq_active), 1);
        run_frame(3, 4, -1, -1, 0, got);
        check(got == 12, "R2 single internal frame", got, 12);
        check(acq_active == 1'b0, "R2 single mode self-disable", int'(acq_active), 0);

        // R3 R5 R6: sweep of mode and line count
        for (int cont = 0; cont < 2; cont++) begin
            for (int fl = 0; fl < 5; fl++) begin
                frame_lines = LW'(fl);
                do_write(32'h4 | 32'(cont));
                check(acq_active == 1'b1, "R2 arm", int'(acq_active), 1);
                eff = (fl == 0 || fl > 3) ? 3 : fl;
                for (int f = 0; f < 3; f++) begin
                    run_frame(3, 4, -1, -1, 0, got);
                    exp = (cont == 1 || f == 0) ? eff * 4 : 0;
                    if (fl == 0 || fl > 3)
                        check(got == exp, "R6 frame end closes window", got, exp);
                    else if (cont == 1)
                        check(got == exp, "R3 continuous frame", got, exp);
                    else
                        check(got == exp, "R5 single frame line count", got, exp);
                    if (f == 0)
                        check(int'(acq_active) == cont, "R5 status after first frame", int'(acq_active), cont);
                end
                do_write(32'h0);
            end
        end

        // R4: arming during a frame skips the rest of that frame
        frame_lines = '0;
        run_frame(3, 4, 1, -1, 32'h5, got);
        check(got == 0, "R4 frame in progress skipped", got, 0);
        run_frame(3, 4, -1, -1, 0, got);
        check(got == 12, "R4 next clean frame passes", got, 12);
        do_write(32'h0);

        // R7: abort in the middle of a line
        do_write(32'h5);
        run_frame(3, 4, 1, 2, 32'hFFFF_FFFB, got);
        check(got == 6, "R7 abort mid-line", got, 6);
        check(acq_active == 1'b0, "R7 status after abort", int'(acq_active), 0);
        run_frame(3, 4, -1, -1, 0, got);
        check(got == 0, "R7 nothing after abort", got, 0);

        // R9 and R8: external trigger
        frame_lines = LW'(2);
        pulse_trig();
        do_write(32'h6);
        run_frame(3, 4, -1, -1, 0, got);
        check(got == 0, "R9 trigger before arming ignored", got, 0);
        check(acq_active == 1'b1, "R9 still armed", int'(acq_active), 1);
        pulse_trig();
        run_frame(3, 4, -1, -1, 0, got);
        check(got == 8, "R8 triggered single frame", got, 8);
        check(acq_active == 1'b0, "R8 single self-disable", int'(acq_active), 0);
        do_write(32'h7);
        run_frame(3, 4, -1, -1, 0, got);
        check(got == 0, "R8 continuous waits for trigger", got, 0);
        pulse_trig();
        run_frame(3, 4, -1, -1, 0, got);
        check(got == 8, "R8 continuous triggered frame", got, 8);
        run_frame(3, 4, -1, -1, 0, got);
        check(got == 0, "R8 one frame per trigger", got, 0);
        pulse_trig();
        run_frame(3, 4, -1, -1, 0, got);
        check(got == 8, "R8 second trigger", got, 8);
        do_write(32'h0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule